// File: doc/BRIEF.md
# Timer Tick Prescaler

This block turns the system clock into a count-enable pulse for a timer counter. A 3-bit select input picks the pulse source. Code 0 stops the timer. Codes 1 to 5 take a tap from a free-running 10-bit divider. Codes 6 and 7 follow edges on an external clock pin, which is first passed through a synchronizer. The counter that consumes the pulse advances by one on each cycle in which `tick` is high.

No data stream crosses the block's edge. There is no valid/ready handshake: the select input and the external pin are plain level inputs, and the tick output is a plain pulse that the counter is always ready to take. While the select is 0, the divider is held at zero. Starting the timer therefore always begins a fresh divide period.

Top module: `count_tick_gen`

## Requirements
- R1: During reset and in the first cycle after it, `tick` is low.
- R2: With `sel` = 0, `tick` stays low, and toggling `ext_clk` has no effect.
- R3: With `sel` = 1, 2, 3, 4 or 5 held steady, `tick` is high for one cycle in every 1, 8, 64, 256 or 1024 cycles respectively.
- R4: When `sel` goes from 0 to a divider code with ratio N, the divider starts from zero. The first `tick` is high in the cycle after the N-th rising clock edge that samples the new code.
- R5: With `sel` = 7, each rising edge on `ext_clk` gives exactly one tick. The tick is high in the cycle after the third clock edge that follows the edge on the pin, which covers two synchronizer flops and one output flop.
- R6: With `sel` = 6, each falling edge on `ext_clk` gives exactly one tick, with the same three-edge latency as R5. Rising edges give no tick in this mode.
- R7: Every tick is one system-clock cycle wide. While `sel` stays on any code other than 1, `tick` is never high in two consecutive cycles.
- R8: In divider modes, `ext_clk` has no effect on `tick`. Changing `sel` directly from one divider code to another does not restart the divider: the next tick comes when the divider's low bits reach the new ratio minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Source select: 0 stop, 1..5 divide by 1/8/64/256/1024, 6 external falling edge, 7 external rising edge |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| tick | output | 1 | Registered count-enable pulse |

## Verification
The hardest cases to reach from the ports are those where divider phase and select history meet: a direct switch from one ratio to another in mid-count, and a restart after stop, where the first tick must land exactly one period later. The stimulus walks through all codes, stops and restarts, and switches ratios without stopping. A reference model tracks the divider phase as an integer, so every one of these paths is compared cycle by cycle. The external pin is toggled in every mode, including stop and divider modes, so that the checks show edges are ignored where they should be.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_D1       = 3'd1,
    SEL_D8       = 3'd2,
    SEL_D64      = 3'd3,
    SEL_D256     = 3'd4,
    SEL_D1024    = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } sel_code_e;

  localparam int NUM_TAPS = 5;

  // log2 of the division ratio for divider tap idx (1..NUM_TAPS)
  function automatic int tap_shift(input int idx);
    case (idx)
      1:       return 0;
      2:       return 3;
      3:       return 6;
      4:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int N_TAP = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [N_TAP:1]   taps
);

  localparam logic [DIV_W-1:0] STEP = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt;

  // held at zero while stopped so a start always begins a fresh period
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + STEP;
  end

  for (genvar gi = 1; gi <= N_TAP; gi++) begin : g_tap
    localparam int SH = tap_shift(gi);
    if (SH == 0) begin : g_every
      assign taps[gi] = run;
    end else if (SH > DIV_W) begin : g_none
      assign taps[gi] = 1'b0;
    end else begin : g_lowbits
      assign taps[gi] = run & (&cnt[SH-1:0]);
    end
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&cnt)) |=> (cnt == '0))
    else $error("divider did not wrap to zero");

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0))
    else $error("divider not at zero on start");

endmodule

// File: rtl/ext_edge_det.sv
module ext_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], pin};
  end

  assign rise =  shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
  assign fall = ~shreg[SYNC_STAGES-1] &  shreg[SYNC_STAGES];

  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise)
    else $error("rise pulse longer than one cycle");

  p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall)
    else $error("fall pulse longer than one cycle");

endmodule

// File: rtl/tick_select.sv
module tick_select
  import tick_pkg::*;
#(
  parameter int N_TAP = NUM_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sel_code_e       sel,
  input  logic [N_TAP:1]  taps,
  input  logic            rise,
  input  logic            fall,
  output logic            tick
);

  logic pick;

  always_comb begin
    case (sel)
      SEL_OFF:      pick = 1'b0;
      SEL_D1:       pick = taps[1];
      SEL_D8:       pick = taps[2];
      SEL_D64:      pick = taps[3];
      SEL_D256:     pick = taps[4];
      SEL_D1024:    pick = taps[5];
      SEL_EXT_FALL: pick = fall;
      SEL_EXT_RISE: pick = rise;
      default:      pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= pick;
  end

  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_OFF) |=> !tick)
    else $error("tick while stopped");

  p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != SEL_D1 && sel == $past(sel)) |=> !tick)
    else $error("tick wider than one cycle");

endmodule

// File: rtl/count_tick_gen.sv
module count_tick_gen
  import tick_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_clk,
  output logic       tick
);

  sel_code_e            sel_e;
  logic                 run;
  logic [NUM_TAPS:1]    taps;
  logic                 ext_rise;
  logic                 ext_fall;

  assign sel_e = sel_code_e'(sel);
  assign run   = (sel_e != SEL_OFF);

  tick_divider #(.DIV_W(DIV_W), .N_TAP(NUM_TAPS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .taps  (taps)
  );

  ext_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_clk),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  tick_select #(.N_TAP(NUM_TAPS)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_e),
    .taps  (taps),
    .rise  (ext_rise),
    .fall  (ext_fall),
    .tick  (tick)
  );

endmodule

// File: tb/sim_count_tick_gen.sv
`timescale 1ns/1ps
module sim_count_tick_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       ext_clk = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  count_tick_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  // ---------------- reference model ----------------
  int  phase = 0;        // divider position, integer
  int  ext_q[$];         // pin samples, one per edge
  bit  exp_tick = 1'b0;
  string exp_tag = "R1";

  function automatic int ratio_of(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      phase = 0;
      ext_q = {0, 0, 0, 0};
      exp_tick = 1'b0;
      exp_tag = "R1";
    end else begin
      int n;
      int s;
      bit r2, r3;
      ext_q.push_back(int'(ext_clk));
      while (ext_q.size() > 4) void'(ext_q.pop_front());
      r2 = ext_q[1][0];  // sample two edges back
      r3 = ext_q[0][0];  // sample three edges back
      s = int'(sel);
      n = ratio_of(s);
      if (s == 0) begin
        exp_tick = 1'b0; exp_tag = "R2"; phase = 0;
      end else begin
        if (s == 7)      begin exp_tick = r2 & ~r3; exp_tag = "R5"; end
        else if (s == 6) begin exp_tick = ~r2 & r3; exp_tag = "R6"; end
        else begin exp_tick = ((phase % n) == n - 1); exp_tag = "R3/R8"; end
        phase = (phase + 1) % 1024;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  // cycle compare on every falling edge
  always @(negedge clk) begin
    if (!done) chk(tick === exp_tick, exp_tag, int'(tick), int'(exp_tick));
  end

  // R7: width check while select steady and not divide-by-1
  bit   prev_tick = 1'b0;
  logic [2:0] prev_sel = 3'd0;
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (prev_tick && tick && sel == prev_sel && sel != 3'd1)
        chk(1'b0, "R7", 1, 0);
    end
    prev_tick = tick;
    prev_sel  = sel;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic first_tick(input int code, input int n_exp);
    int n = 0;
    @(negedge clk); sel = 3'd0;
    wait_cyc(3);
    sel = code[2:0];
    do begin @(negedge clk); n++; end while (!tick && n < 5000);
    chk(n == n_exp, "R4", n, n_exp);
  endtask

  task automatic window(input int code, input int reps, input bit wiggle, input string tag);
    int n = ratio_of(code);
    int cnt = 0;
    @(negedge clk); sel = 3'd0;
    wait_cyc(2);
    sel = code[2:0];
    repeat (n * reps) begin
      @(negedge clk);
      if (tick) cnt++;
      if (wiggle) ext_clk = ~ext_clk;
    end
    chk(cnt == reps, tag, cnt, reps);
  endtask

  task automatic ext_run(input int code, input int edges, input int hi, input int lo,
                         input string tag, input int expected);
    int cnt = 0;
    @(negedge clk); ext_clk = 1'b0; sel = code[2:0];
    repeat (5) begin @(negedge clk); if (tick) cnt++; end
    cnt = 0;
    repeat (edges) begin
      ext_clk = 1'b1;
      repeat (hi) begin @(negedge clk); if (tick) cnt++; end
      ext_clk = 1'b0;
      repeat (lo) begin @(negedge clk); if (tick) cnt++; end
    end
    repeat (5) begin @(negedge clk); if (tick) cnt++; end
    chk(cnt == expected, tag, cnt, expected);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    wait_cyc(4);
    chk(tick === 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick === 1'b0, "R1", int'(tick), 0);

    // R2: stopped, pin toggling
    begin
      int cnt = 0;
      sel = 3'd0;
      repeat (40) begin @(negedge clk); ext_clk = ~ext_clk; if (tick) cnt++; end
      chk(cnt == 0, "R2", cnt, 0);
      ext_clk = 1'b0;
      wait_cyc(4);
    end

    // R4: first tick latency after a start
    first_tick(1, 1);
    first_tick(2, 8);
    first_tick(3, 64);
    first_tick(4, 256);

    // R3: tick counts per window for each ratio
    window(1, 16, 1'b0, "R3");
    window(2, 6, 1'b0, "R3");
    window(3, 4, 1'b0, "R3");
    window(4, 3, 1'b0, "R3");
    window(5, 2, 1'b0, "R3");

    // R8: pin toggling in divider mode
    window(2, 8, 1'b1, "R8");
    ext_clk = 1'b0;

    // R8: direct ratio switches in mid-count (model compares each cycle)
    @(negedge clk); sel = 3'd3; wait_cyc(37);
    sel = 3'd2; wait_cyc(29);
    sel = 3'd4; wait_cyc(300);
    sel = 3'd1; wait_cyc(5);
    sel = 3'd2; wait_cyc(20);

    // R5: rising edges, varied spacing
    ext_run(7, 6, 1, 1, "R5", 6);
    ext_run(7, 4, 3, 5, "R5", 4);
    // R6: falling edges
    ext_run(6, 6, 1, 1, "R6", 6);
    ext_run(6, 3, 7, 2, "R6", 3);

    // switch between external modes and stop
    @(negedge clk); sel = 3'd7; ext_clk = 1'b1; wait_cyc(6);
    sel = 3'd6; ext_clk = 1'b0; wait_cyc(6);
    sel = 3'd0; ext_clk = 1'b1; wait_cyc(6);
    sel = 3'd5; wait_cyc(10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule